// File: doc/BRIEF.md
# Quarter-Rate IF Carrier Demodulator

This block turns a stream of real samples, taken at exactly four times a fixed intermediate frequency, into baseband in-phase (I) and quadrature (Q) components of the residual carrier. Because the sample clock is four times the IF, consecutive samples carry Q and I content in turn. The mix to baseband therefore needs no multiplier. The sample index is counted modulo four, which steers each sample to the I or Q stream, and the sample is either added or subtracted.

Each stream is summed over a window of N sample pairs. N is set at run time on an input port. The window sum is dumped as one decimated I/Q word at the loop update rate, which suits a software carrier loop filter. With every dump the block also delivers a signed lock metric, |I| − |Q|, computed on the same window sums. It drives a carrier lock detector.

Top module: `qrate_carrier_demod`

## Requirements
- R1: A running index k counts accepted samples modulo 4, starting at 0. The sample at k=0 is added to Q, at k=1 added to I, at k=2 subtracted from Q and at k=3 subtracted from I.
- R2: A pair ends on each accepted sample with odd k. When the number of completed pairs in the current window reaches `win_pairs`, sampled at that pair's end, the window is dumped. A value of 0 is treated as 1. If `win_pairs` is lowered below the pairs already counted, the dump happens at the next pair end.
- R3: The dumped I and Q words are the exact signed sums of the window. No overflow occurs for any `win_pairs` value up to 2^LEN_W−1 with full-scale samples of either sign.
- R4: Each dump includes the sample that closes the window. The sample after it starts a fresh window from zero.
- R5: `lock_out` equals |`i_out`| − |`q_out`| of the same dump. It is a signed word one bit wider than `i_out` and is valid with `out_valid`.
- R6: `out_valid` is a single-cycle pulse. It is high in the cycle after the clock edge that accepted the closing sample. The output words hold their value between pulses.
- R7: A synchronous active-high `rst` clears the index, the pair count, both sums, the output words and `out_valid`. The first sample accepted after reset is taken as k=0.
- R8: A cycle with `smp_valid` low changes neither the index, the pair count nor the sums, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Signed ADC sample, two's complement |
| win_pairs | input | LEN_W | Window length in sample pairs (0 acts as 1) |
| out_valid | output | 1 | Dump strobe |
| i_out | output | SAMPLE_W+LEN_W+1 | Decimated in-phase sum, signed |
| q_out | output | SAMPLE_W+LEN_W+1 | Decimated quadrature sum, signed |
| lock_out | output | SAMPLE_W+LEN_W+2 | Lock metric \|I\|−\|Q\|, signed |

## Verification
The window dump and the start of the next window's accumulation can both occur in one clock cycle. In that cycle the closing sample must reach the dumped word, and the accumulators must restart from zero. The bench provokes this with `win_pairs` of 0 and 1 under an unbroken strobe, and with a shortened window in mid-stream. It then compares every dumped I, Q and lock value with a bench model that assigns the closing sample to the old window and the next sample to the new one. An error in either direction shows up as an off-by-one-sample sum in the next dump.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  // Position of a sample within the 4x-IF cycle; bit 0 selects I, bit 1 the sign.
  typedef enum logic [1:0] {
    PH_Q_POS = 2'd0,
    PH_I_POS = 2'd1,
    PH_Q_NEG = 2'd2,
    PH_I_NEG = 2'd3
  } phase_e;
endpackage

// File: rtl/qrd_sequencer.sv
module qrd_sequencer
  import qrd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [LEN_W-1:0] win_pairs,
  output phase_e           phase,
  output logic             dump
);
  localparam int CNT_W = LEN_W + 1;

  phase_e           phase_q;
  logic [LEN_W-1:0] pair_cnt_q;
  logic [LEN_W-1:0] eff_len;
  logic [CNT_W-1:0] pairs_now;

  assign eff_len   = (win_pairs == '0) ? LEN_W'(1) : win_pairs;
  assign pairs_now = CNT_W'(pair_cnt_q) + CNT_W'(1);
  assign phase     = phase_q;
  assign dump      = smp_valid && phase_q[0] && (pairs_now >= CNT_W'(eff_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_Q_POS;
      pair_cnt_q <= '0;
    end else if (smp_valid) begin
      phase_q <= phase_e'(phase_q + 2'd1);
      if (phase_q[0]) begin
        pair_cnt_q <= dump ? '0 : pairs_now[LEN_W-1:0];
      end
    end
  end

  // R1: index advances by one per accepted sample
  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> phase_q == phase_e'($past(phase_q) + 2'd1));

  // R8: idle cycles leave index and pair count untouched
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(phase_q) && $stable(pair_cnt_q)));

  // R2: a pair end that does not close the window increments the count
  assert_pair_count_R2: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && phase_q[0] && !dump) |=> pair_cnt_q == $past(pair_cnt_q) + LEN_W'(1));

  // R4: a dump restarts the pair count
  assert_window_restart_R4: assert property (@(posedge clk) disable iff (rst)
    dump |=> pair_cnt_q == '0);
endmodule

// File: rtl/qrd_chan_acc.sv
module qrd_chan_acc
  import qrd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 29,
  parameter bit IS_I     = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  phase_e                     phase,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic                       dump,
  output logic signed [ACC_W-1:0]    sum_now
);
  localparam int EXT_W = ACC_W - SAMPLE_W;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] contrib;
  logic                    mine;

  assign mine    = smp_valid && (phase[0] == IS_I);
  assign ext     = {{EXT_W{sample[SAMPLE_W-1]}}, sample};
  assign contrib = !mine ? '0 : (phase[1] ? -ext : ext);
  assign sum_now = acc_q + contrib;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (smp_valid) begin
      acc_q <= dump ? '0 : sum_now;
    end
  end

  // R3: adding same-signed terms never flips the sign of the sum
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (mine && (acc_q[ACC_W-1] == contrib[ACC_W-1])) |-> (sum_now[ACC_W-1] == acc_q[ACC_W-1]));

  // R4: sum is zero right after a dump
  assert_clear_on_dump_R4: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && dump) |=> acc_q == '0);

  // R8: idle cycles leave the sum untouched
  assert_idle_acc_R8: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(acc_q));
endmodule

// File: rtl/qrd_lock_metric.sv
module qrd_lock_metric #(
  parameter int ACC_W = 29
) (
  input  logic signed [ACC_W-1:0] i_sum,
  input  logic signed [ACC_W-1:0] q_sum,
  output logic signed [ACC_W:0]   metric
);
  logic signed [ACC_W:0] i_ext;
  logic signed [ACC_W:0] q_ext;
  logic signed [ACC_W:0] i_mag;
  logic signed [ACC_W:0] q_mag;

  assign i_ext  = {i_sum[ACC_W-1], i_sum};
  assign q_ext  = {q_sum[ACC_W-1], q_sum};
  assign i_mag  = i_ext[ACC_W] ? -i_ext : i_ext;
  assign q_mag  = q_ext[ACC_W] ? -q_ext : q_ext;
  assign metric = i_mag - q_mag;
endmodule

// File: rtl/qrate_carrier_demod.sv
module qrate_carrier_demod
  import qrd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int LEN_W    = 16,
  localparam int ACC_W   = SAMPLE_W + LEN_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp_data,
  input  logic [LEN_W-1:0]           win_pairs,
  output logic                       out_valid,
  output logic signed [ACC_W-1:0]    i_out,
  output logic signed [ACC_W-1:0]    q_out,
  output logic signed [ACC_W:0]      lock_out
);
  phase_e                  phase;
  logic                    dump;
  logic signed [ACC_W-1:0] sums [2];
  logic signed [ACC_W:0]   metric;

  qrd_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .win_pairs (win_pairs),
    .phase     (phase),
    .dump      (dump)
  );

  // Channel 0 carries Q (even index), channel 1 carries I (odd index)
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    qrd_chan_acc #(
      .SAMPLE_W (SAMPLE_W),
      .ACC_W    (ACC_W),
      .IS_I     (ch == 1)
    ) u_acc (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (smp_valid),
      .phase     (phase),
      .sample    (smp_data),
      .dump      (dump),
      .sum_now   (sums[ch])
    );
  end

  qrd_lock_metric #(.ACC_W(ACC_W)) u_lock (
    .i_sum  (sums[1]),
    .q_sum  (sums[0]),
    .metric (metric)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      i_out     <= '0;
      q_out     <= '0;
      lock_out  <= '0;
    end else begin
      out_valid <= dump;
      if (dump) begin
        i_out    <= sums[1];
        q_out    <= sums[0];
        lock_out <= metric;
      end
    end
  end

  // R6: the strobe never lasts two cycles
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: words hold when no dump occurred
  assert_hold_words_R6: assert property (@(posedge clk) disable iff (rst)
    !dump |=> ($stable(i_out) && $stable(q_out) && $stable(lock_out)));

  // R5: lock metric agrees with the registered I and Q words
  assert_lock_metric_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> lock_out == (((i_out < 0) ? -(ACC_W+1)'(i_out) : (ACC_W+1)'(i_out))
                             - ((q_out < 0) ? -(ACC_W+1)'(q_out) : (ACC_W+1)'(q_out))));

  // R7: reset clears the outputs
  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> (!out_valid && i_out == '0 && q_out == '0 && lock_out == '0));
endmodule

// File: tb/qrate_carrier_demod_bench.sv
`timescale 1ns/1ps
module qrate_carrier_demod_bench;
  localparam int SAMPLE_W = 12;
  localparam int LEN_W    = 16;
  localparam int ACC_W    = SAMPLE_W + LEN_W + 1;

  logic                       clk = 1'b0;
  logic                       rst = 1'b1;
  logic                       smp_valid = 1'b0;
  logic signed [SAMPLE_W-1:0] smp_data = '0;
  logic [LEN_W-1:0]           win_pairs = '0;
  logic                       out_valid;
  logic signed [ACC_W-1:0]    i_out;
  logic signed [ACC_W-1:0]    q_out;
  logic signed [ACC_W:0]      lock_out;

  always #2.5 clk = ~clk;

  qrate_carrier_demod #(.SAMPLE_W(SAMPLE_W), .LEN_W(LEN_W)) u_qrate_carrier_demod (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .win_pairs(win_pairs), .out_valid(out_valid), .i_out(i_out),
    .q_out(q_out), .lock_out(lock_out)
  );

  int     checks = 0;
  int     errors = 0;
  bit     done = 0;
  string  cur_req = "R1";

  // reference model
  longint m_i = 0, m_q = 0;
  int     m_k = 0, m_pairs = 0;
  bit     exp_v = 0;
  longint exp_i = 0, exp_q = 0, exp_l = 0;

  function automatic longint mag(input longint x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic compare();
    if (exp_v || out_valid) begin
      checks++;
      if (out_valid !== exp_v || longint'(i_out) != exp_i || longint'(q_out) != exp_q
          || longint'(lock_out) != exp_l) begin
        errors++;
        $display("FAIL %s valid=%0b/%0b I=%0d/%0d Q=%0d/%0d L=%0d/%0d", cur_req,
                 out_valid, exp_v, i_out, exp_i, q_out, exp_q, lock_out, exp_l);
      end
    end
  endtask

  task automatic cyc(input bit r, input bit v, input int d, input int n);
    int effn;
    @(negedge clk);
    compare();
    rst = r; smp_valid = v; smp_data = SAMPLE_W'(d); win_pairs = LEN_W'(n);
    exp_v = 0;
    if (r) begin
      m_i = 0; m_q = 0; m_k = 0; m_pairs = 0;
      exp_i = 0; exp_q = 0; exp_l = 0;
    end else if (v) begin
      case (m_k)
        0: m_q += d;
        1: m_i += d;
        2: m_q -= d;
        default: m_i -= d;
      endcase
      if (m_k % 2 == 1) begin
        m_pairs++;
        effn = (n == 0) ? 1 : n;
        if (m_pairs >= effn) begin
          exp_v = 1; exp_i = m_i; exp_q = m_q; exp_l = mag(m_i) - mag(m_q);
          m_i = 0; m_q = 0; m_pairs = 0;
        end
      end
      m_k = (m_k + 1) % 4;
    end
  endtask

  function automatic int rnd_smp();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0042));
    // R7: reset state
    cur_req = "R7";
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1);
    cyc(0, 0, 0, 1);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || i_out != 0 || q_out != 0 || lock_out != 0) begin
      errors++;
      $display("FAIL R7 reset state valid=%0b/0 I=%0d/0 Q=%0d/0 L=%0d/0",
               out_valid, i_out, q_out, lock_out);
    end
    // R1: sign and routing per index, one pair windows
    cur_req = "R1";
    cyc(0, 1, 10, 1); cyc(0, 1, 20, 1); cyc(0, 1, 30, 1); cyc(0, 1, 40, 1);
    cyc(0, 1, -7, 1); cyc(0, 1, 300, 1); cyc(0, 1, -5, 1); cyc(0, 1, -900, 1);
    // R8: idle cycles with garbage data
    cur_req = "R8";
    for (int i = 0; i < 24; i++) cyc(0, (i % 3) == 0, rnd_smp(), 2);
    // R4: win_pairs of 0 acts as 1, dump and new window in one cycle
    cur_req = "R4";
    for (int i = 0; i < 16; i++) cyc(0, 1, rnd_smp(), 0);
    // R2: shorten window in mid-stream
    cur_req = "R2";
    for (int i = 0; i < 10; i++) cyc(0, 1, rnd_smp(), 8);
    for (int i = 0; i < 12; i++) cyc(0, 1, rnd_smp(), 2);
    // R3 and R5: full-scale long window, Q large
    cur_req = "R3";
    for (int i = 0; i < 2000; i++) begin
      case (i % 4)
        0: cyc(0, 1, 2047, 1000);
        1: cyc(0, 1, 3, 1000);
        2: cyc(0, 1, -2048, 1000);
        default: cyc(0, 1, 1, 1000);
      endcase
    end
    cur_req = "R5";
    for (int i = 0; i < 2000; i++) begin
      case (i % 4)
        0: cyc(0, 1, 5, 1000);
        1: cyc(0, 1, -2048, 1000);
        2: cyc(0, 1, 2, 1000);
        default: cyc(0, 1, 2047, 1000);
      endcase
    end
    // R7: reset in mid-window restarts index at 0
    cur_req = "R7";
    for (int i = 0; i < 5; i++) cyc(0, 1, rnd_smp(), 3);
    cyc(1, 1, 1234, 3);
    for (int i = 0; i < 12; i++) cyc(0, 1, rnd_smp(), 3);
    // R6: random stream, gaps, changing window length
    cur_req = "R6";
    n = 4;
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) n = int'($urandom_range(0, 20));
      cyc(0, $urandom_range(0, 3) != 0, rnd_smp(), n);
    end
    cyc(0, 0, 0, n);
    cyc(0, 0, 0, n);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule